// File: doc/BRIEF.md
# Programmable Almost-Flag Offset Registers

This block sits beside a FIFO's storage and turns the FIFO's fill count into three registered, active-low status flags: near-empty, near-full and half-full. The near-empty and near-full thresholds come from two offset registers. Software or a serial loader can reprogram these registers. The storage array, the pointers and the empty and full flags are outside the block. The block only receives the fill count.

The level of the load-select input while master reset is held fixes two things at once: the default value of both offsets, and the single loading method that is then accepted. The first method is parallel loading over the data bus. The second is serial loading, one bit per clock through the serial input. Parallel readback of the offsets over the data output works under either method. A partial reset returns the flags to their reset state and restarts the load, readback and serial sequences. It keeps the offset values and the chosen method.

Top module: `pfo_flag_offsets`

## Requirements
- R1: If ld_sel is 0 while mrst_n is low at a clock edge, both offsets become 127 (0x07F) and the parallel method is selected.
- R2: If ld_sel is 1 while mrst_n is low at a clock edge, both offsets become 1023 (0x3FF) and the serial method is selected.
- R3: On the first cycle after master reset, ae_n is 0, af_n is 1, hf_n is 1 and dout is all zeros.
- R4: Under the parallel method, a clock edge with ld_sel=0 and wr_en_n=0 writes din[9:0] into an offset. The first write after any reset goes to the empty offset, the second to the full offset, and the sequence then alternates.
- R5: A clock edge with ld_sel=0 and rd_en_n=0 loads dout with an offset, zero-extended. The first read after any reset returns the empty offset, the next returns the full offset, and the reads then alternate. This works under both methods. dout changes at no other time except master reset.
- R6: Under the serial method, each clock edge with ser_en_n=0 stores ser_in as the next bit of a 20-bit sequence. Bits 0 to 9 fill the empty offset LSB first, bits 10 to 19 fill the full offset LSB first, and the sequence then wraps to bit 0.
- R7: Parallel writes have no effect under the serial method. Serial shifts have no effect under the parallel method.
- R8: While prst_n is low, the offsets and the method are unchanged, no load takes effect, and the flags take their R3 values. After prst_n is released, the write, readback and serial sequences restart from the empty offset.
- R9: ae_n is 0 one cycle after fill_cnt is less than or equal to the empty offset, and 1 otherwise.
- R10: af_n is 0 one cycle after DEPTH minus fill_cnt is less than or equal to the full offset, and 1 otherwise.
- R11: hf_n is 0 one cycle after fill_cnt exceeds DEPTH/2, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| mrst_n | input | 1 | Synchronous master reset, active low |
| prst_n | input | 1 | Synchronous partial reset, active low |
| ld_sel | input | 1 | Load select; also chooses defaults and method during master reset |
| wr_en_n | input | 1 | Write enable, active low (parallel offset write when ld_sel=0) |
| rd_en_n | input | 1 | Read enable, active low (offset readback when ld_sel=0) |
| ser_en_n | input | 1 | Serial shift enable, active low |
| ser_in | input | 1 | Serial offset data |
| din | input | DATA_W (18) | Parallel offset data, low OFF_W bits used |
| dout | output | DATA_W (18) | Offset readback data |
| fill_cnt | input | CNT_W (12) | Current FIFO word count, 0 to DEPTH |
| ae_n | output | 1 | Near-empty flag, active low |
| af_n | output | 1 | Near-full flag, active low |
| hf_n | output | 1 | Half-full flag, active low |

## Verification
The flags are driven with fill counts one word on each side of every threshold. With distinct empty and full offsets in place, the bench can tell a correct comparison from an off-by-one error or from a swap of the two offsets. The offsets are loaded in both methods with asymmetric bit patterns and then read back. This exposes a wrong write order, an MSB-first shift, or a serial position that partial reset fails to clear. Writes made through the method that is not selected are shown to leave the readback values unchanged. A partial reset applied with the FIFO full separates flag clearing from loss of the offsets.

// File: rtl/pfo_pkg.sv
package pfo_pkg;

  typedef enum logic {
    LOAD_PAR = 1'b0,
    LOAD_SER = 1'b1
  } load_mode_e;

  function automatic logic near_empty(input int unsigned cnt, input int unsigned off);
    return cnt <= off;
  endfunction

  function automatic logic near_full(input int unsigned cnt, input int unsigned off,
                                     input int unsigned depth);
    if (cnt >= depth) return 1'b1;
    return (depth - cnt) <= off;
  endfunction

  function automatic logic over_half(input int unsigned cnt, input int unsigned depth);
    return cnt > (depth / 2);
  endfunction

endpackage

// File: rtl/pfo_offset_bank.sv
module pfo_offset_bank
  import pfo_pkg::*;
#(
  parameter int DATA_W  = 18,
  parameter int OFF_W   = 10,
  parameter int PAR_DEF = 127,
  parameter int SER_DEF = 1023
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              ld_sel,
  input  logic              wr_en_n,
  input  logic              rd_en_n,
  input  logic              ser_en_n,
  input  logic              ser_in,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [OFF_W-1:0]  e_off,
  output logic [OFF_W-1:0]  f_off,
  output logic              ser_mode,
  output logic              par_wr_evt,
  output logic              ser_sh_evt,
  output logic              rb_evt
);

  localparam int SER_BITS = 2 * OFF_W;
  localparam int BP_W     = $clog2(SER_BITS);
  localparam logic [OFF_W-1:0] PAR_V = OFF_W'(PAR_DEF);
  localparam logic [OFF_W-1:0] SER_V = OFF_W'(SER_DEF);
  localparam logic [BP_W-1:0]  BP_LAST = BP_W'(SER_BITS - 1);

  // index 0 = empty offset, index 1 = full offset
  logic [1:0][OFF_W-1:0] off_q;
  logic [SER_BITS-1:0]   flat_nxt;
  logic [BP_W-1:0]       bpos_q;
  logic                  wr_sel_q;
  logic                  rd_sel_q;
  logic [OFF_W-1:0]      rd_val_q;
  load_mode_e            mode_q;
  logic                  active;

  assign active     = mrst_n && prst_n;
  assign ser_mode   = (mode_q == LOAD_SER);
  assign par_wr_evt = active && !ser_mode && !ld_sel && !wr_en_n;
  assign ser_sh_evt = active && ser_mode && !ser_en_n;
  assign rb_evt     = active && !ld_sel && !rd_en_n;
  assign e_off      = off_q[0];
  assign f_off      = off_q[1];

  always_comb begin
    flat_nxt         = off_q;
    flat_nxt[bpos_q] = ser_in;
  end

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      mode_q   <= load_mode_e'(ld_sel);
      off_q    <= ld_sel ? {SER_V, SER_V} : {PAR_V, PAR_V};
      wr_sel_q <= 1'b0;
      rd_sel_q <= 1'b0;
      bpos_q   <= '0;
      rd_val_q <= '0;
    end else if (!prst_n) begin
      wr_sel_q <= 1'b0;
      rd_sel_q <= 1'b0;
      bpos_q   <= '0;
    end else begin
      if (par_wr_evt) begin
        off_q[wr_sel_q] <= din[OFF_W-1:0];
        wr_sel_q        <= ~wr_sel_q;
      end
      if (ser_sh_evt) begin
        off_q  <= flat_nxt;
        bpos_q <= (bpos_q == BP_LAST) ? '0 : bpos_q + 1'b1;
      end
      if (rb_evt) begin
        rd_val_q <= off_q[rd_sel_q];
        rd_sel_q <= ~rd_sel_q;
      end
    end
  end

  generate
    if (DATA_W > OFF_W) begin : g_pad
      logic din_unused;
      assign din_unused = ^din[DATA_W-1:OFF_W];
      assign dout = {{(DATA_W-OFF_W){1'b0}}, rd_val_q};
    end else begin : g_nopad
      assign dout = rd_val_q[DATA_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/pfo_flag_gen.sv
module pfo_flag_gen
  import pfo_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int CNT_W = 12,
  parameter int OFF_W = 10
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             prst_n,
  input  logic [CNT_W-1:0] fill_cnt,
  input  logic [OFF_W-1:0] e_off,
  input  logic [OFF_W-1:0] f_off,
  output logic             ae_n,
  output logic             af_n,
  output logic             hf_n
);

  logic ae_hit, af_hit, hf_hit;

  assign ae_hit = near_empty(32'(fill_cnt), 32'(e_off));
  assign af_hit = near_full(32'(fill_cnt), 32'(f_off), 32'(DEPTH));
  assign hf_hit = over_half(32'(fill_cnt), 32'(DEPTH));

  always_ff @(posedge clk) begin
    if (!mrst_n || !prst_n) begin
      ae_n <= 1'b0;
      af_n <= 1'b1;
      hf_n <= 1'b1;
    end else begin
      ae_n <= !ae_hit;
      af_n <= !af_hit;
      hf_n <= !hf_hit;
    end
  end

endmodule

// File: rtl/pfo_flag_offsets.sv
module pfo_flag_offsets #(
  parameter int DEPTH   = 2048,
  parameter int DATA_W  = 18,
  parameter int OFF_W   = 10,
  parameter int PAR_DEF = 127,
  parameter int SER_DEF = 1023,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              ld_sel,
  input  logic              wr_en_n,
  input  logic              rd_en_n,
  input  logic              ser_en_n,
  input  logic              ser_in,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  input  logic [CNT_W-1:0]  fill_cnt,
  output logic              ae_n,
  output logic              af_n,
  output logic              hf_n
);

  logic [OFF_W-1:0] e_off;
  logic [OFF_W-1:0] f_off;
  logic             ser_mode;
  logic             par_wr_evt;
  logic             ser_sh_evt;
  logic             rb_evt;

  pfo_offset_bank #(
    .DATA_W (DATA_W),
    .OFF_W  (OFF_W),
    .PAR_DEF(PAR_DEF),
    .SER_DEF(SER_DEF)
  ) u_bank (
    .clk       (clk),
    .mrst_n    (mrst_n),
    .prst_n    (prst_n),
    .ld_sel    (ld_sel),
    .wr_en_n   (wr_en_n),
    .rd_en_n   (rd_en_n),
    .ser_en_n  (ser_en_n),
    .ser_in    (ser_in),
    .din       (din),
    .dout      (dout),
    .e_off     (e_off),
    .f_off     (f_off),
    .ser_mode  (ser_mode),
    .par_wr_evt(par_wr_evt),
    .ser_sh_evt(ser_sh_evt),
    .rb_evt    (rb_evt)
  );

  pfo_flag_gen #(
    .DEPTH(DEPTH),
    .CNT_W(CNT_W),
    .OFF_W(OFF_W)
  ) u_flags (
    .clk     (clk),
    .mrst_n  (mrst_n),
    .prst_n  (prst_n),
    .fill_cnt(fill_cnt),
    .e_off   (e_off),
    .f_off   (f_off),
    .ae_n    (ae_n),
    .af_n    (af_n),
    .hf_n    (hf_n)
  );

endmodule

// File: rtl/pfo_checker.sv
module pfo_checker #(
  parameter int DEPTH   = 2048,
  parameter int DATA_W  = 18,
  parameter int OFF_W   = 10,
  parameter int PAR_DEF = 127,
  parameter int SER_DEF = 1023,
  parameter int CNT_W   = 12
) (
  input logic              clk,
  input logic              mrst_n,
  input logic              prst_n,
  input logic              ld_sel,
  input logic              wr_en_n,
  input logic              ser_en_n,
  input logic [CNT_W-1:0]  fill_cnt,
  input logic [DATA_W-1:0] dout,
  input logic              ae_n,
  input logic              af_n,
  input logic              hf_n,
  input logic [OFF_W-1:0]  e_off,
  input logic [OFF_W-1:0]  f_off,
  input logic              ser_mode,
  input logic              rb_evt
);

  localparam logic [OFF_W-1:0] PAR_V  = OFF_W'(PAR_DEF);
  localparam logic [OFF_W-1:0] SER_V  = OFF_W'(SER_DEF);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

  assert_par_default_R1: assert property (@(posedge clk) disable iff (!mrst_n)
    ($rose(mrst_n) && !ser_mode) |-> (e_off == PAR_V && f_off == PAR_V));

  assert_ser_default_R2: assert property (@(posedge clk) disable iff (!mrst_n)
    ($rose(mrst_n) && ser_mode) |-> (e_off == SER_V && f_off == SER_V));

  assert_reset_state_R3: assert property (@(posedge clk) disable iff (!mrst_n)
    $rose(mrst_n) |-> (!ae_n && af_n && hf_n && dout == '0));

  assert_dout_hold_R5: assert property (@(posedge clk) disable iff (!mrst_n)
    !rb_evt |=> $stable(dout));

  assert_par_locked_R7: assert property (@(posedge clk) disable iff (!mrst_n)
    (ser_mode && prst_n && !ld_sel && !wr_en_n && ser_en_n) |=>
      ($stable(e_off) && $stable(f_off)));

  assert_prst_keep_R8: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> ($stable(e_off) && $stable(f_off) && $stable(ser_mode)));

  assert_empty_ae_R9: assert property (@(posedge clk) disable iff (!mrst_n)
    (fill_cnt == '0) |=> !ae_n);

  assert_full_flags_R10: assert property (@(posedge clk) disable iff (!mrst_n)
    (fill_cnt == FULL_C && prst_n) |=> (!af_n && !hf_n));

endmodule

bind pfo_flag_offsets pfo_checker #(
  .DEPTH  (DEPTH),
  .DATA_W (DATA_W),
  .OFF_W  (OFF_W),
  .PAR_DEF(PAR_DEF),
  .SER_DEF(SER_DEF),
  .CNT_W  (CNT_W)
) u_chk (
  .clk     (clk),
  .mrst_n  (mrst_n),
  .prst_n  (prst_n),
  .ld_sel  (ld_sel),
  .wr_en_n (wr_en_n),
  .ser_en_n(ser_en_n),
  .fill_cnt(fill_cnt),
  .dout    (dout),
  .ae_n    (ae_n),
  .af_n    (af_n),
  .hf_n    (hf_n),
  .e_off   (e_off),
  .f_off   (f_off),
  .ser_mode(ser_mode),
  .rb_evt  (rb_evt)
);

// File: tb/test_pfo_flag_offsets.sv
`timescale 1ns/1ps
module test_pfo_flag_offsets;

  localparam int DEPTH  = 2048;
  localparam int DATA_W = 18;
  localparam int CNT_W  = 12;

  logic              clk = 1'b0;
  logic              mrst_n = 1'b0;
  logic              prst_n = 1'b1;
  logic              ld_sel = 1'b0;
  logic              wr_en_n = 1'b1;
  logic              rd_en_n = 1'b1;
  logic              ser_en_n = 1'b1;
  logic              ser_in = 1'b0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic [CNT_W-1:0]  fill_cnt = '0;
  logic              ae_n, af_n, hf_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pfo_flag_offsets i_pfo_flag_offsets (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ld_sel(ld_sel),
    .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .ser_en_n(ser_en_n), .ser_in(ser_in),
    .din(din), .dout(dout), .fill_cnt(fill_cnt),
    .ae_n(ae_n), .af_n(af_n), .hf_n(hf_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic master_reset(input logic sel);
    mrst_n = 1'b0; ld_sel = sel; fill_cnt = '0;
    wr_en_n = 1'b1; rd_en_n = 1'b1; ser_en_n = 1'b1;
    step(); step();
    mrst_n = 1'b1; ld_sel = 1'b0;
  endtask

  task automatic readback(input int exp_e, input int exp_f, input string req);
    ld_sel = 1'b0; rd_en_n = 1'b0;
    step(); chk({req, " readback empty"}, int'(dout), exp_e);
    step(); chk({req, " readback full"}, int'(dout), exp_f);
    rd_en_n = 1'b1;
  endtask

  task automatic par_write(input int val);
    ld_sel = 1'b0; wr_en_n = 1'b0; din = DATA_W'(val);
    step();
    wr_en_n = 1'b1;
  endtask

  task automatic ser_shift(input int nbits, input logic [19:0] val);
    ser_en_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      ser_in = val[i];
      step();
    end
    ser_en_n = 1'b1;
  endtask

  task automatic flags_at(input int cnt, input int e_ae, input int e_af,
                          input int e_hf, input string req);
    fill_cnt = CNT_W'(cnt);
    step();
    chk({req, " ae_n"}, int'(ae_n), e_ae);
    chk({req, " af_n"}, int'(af_n), e_af);
    chk({req, " hf_n"}, int'(hf_n), e_hf);
  endtask

  // R1 R3: parallel defaults and reset state
  task automatic t_reset_par();
    master_reset(1'b0);
    chk("R3 ae_n", int'(ae_n), 0);
    chk("R3 af_n", int'(af_n), 1);
    chk("R3 hf_n", int'(hf_n), 1);
    chk("R3 dout", int'(dout), 0);
    readback(127, 127, "R1");
  endtask

  // R4 R5: parallel write order and readback alternation
  task automatic t_par_load();
    par_write('h3F055);
    par_write('h2AA);
    readback('h055, 'h2AA, "R4");
    par_write('h011);
    readback('h011, 'h2AA, "R5");
  endtask

  // R9 R10 R11: thresholds with e=0x011 (17), f=0x2AA (682)
  task automatic t_flags();
    flags_at(17, 0, 1, 1, "R9 at offset");
    flags_at(18, 1, 1, 1, "R9 above offset");
    flags_at(1024, 1, 1, 1, "R11 at half");
    flags_at(1025, 1, 1, 0, "R11 above half");
    flags_at(DEPTH - 683, 1, 1, 0, "R10 outside offset");
    flags_at(DEPTH - 682, 1, 0, 0, "R10 at offset");
    flags_at(DEPTH, 1, 0, 0, "R10 full");
    flags_at(0, 0, 1, 1, "R9 empty");
  endtask

  // R7: serial shifts ignored in parallel method
  task automatic t_ser_ignored();
    ser_shift(20, 20'hFFFFF);
    readback('h011, 'h2AA, "R7 serial ignored");
  endtask

  // R8: partial reset in parallel method
  task automatic t_prst_par();
    fill_cnt = CNT_W'(DEPTH);
    step();
    chk("R8 pre af_n", int'(af_n), 0);
    par_write('h044);             // lands in full offset (fourth write)
    prst_n = 1'b0;
    par_write('h3CC);             // ignored while held
    chk("R8 held ae_n", int'(ae_n), 0);
    chk("R8 held af_n", int'(af_n), 1);
    chk("R8 held hf_n", int'(hf_n), 1);
    prst_n = 1'b1;
    step();
    chk("R8 released af_n", int'(af_n), 0);
    chk("R8 released hf_n", int'(hf_n), 0);
    fill_cnt = '0;
    par_write('h033);             // sequence restarted: empty offset
    readback('h033, 'h044, "R8 parallel");
  endtask

  // R2 R6 R7 R8: serial method
  task automatic t_serial();
    master_reset(1'b1);
    readback(1023, 1023, "R2");
    par_write('h155);
    readback(1023, 1023, "R7 parallel ignored");
    ser_shift(20, {10'h0F0, 10'h123});
    readback('h123, 'h0F0, "R6");
    ser_shift(5, 20'hFFFFF);
    prst_n = 1'b0;
    step();
    prst_n = 1'b1;
    ser_shift(20, {10'h201, 10'h00E});
    readback('h00E, 'h201, "R8 serial restart");
    ser_shift(10, {10'h000, 10'h2C3});
    readback('h2C3, 'h201, "R6 partial sequence");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset_par();
    t_par_load();
    t_flags();
    t_ser_ignored();
    t_prst_par();
    t_serial();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule